// File: doc/BRIEF.md
# Inset Field Capture with Decimation

This block stores a shrunken copy of a second video source into an on-chip field memory. The source does not share the main picture's timing. Digitized luma and two colour-difference samples arrive with a valid flag, a start-of-line strobe and a start-of-field strobe. The block keeps one sample out of every three or four in each line, and one line out of every three or four lines. Three-to-one gives the larger inset, one ninth of the screen area. Four-to-one gives the smaller inset, one sixteenth of the area. Each kept pixel is written to memory as three 8-bit words.

A vertical filter can be switched on. It replaces each stored line with a 1/4, 1/2, 1/4 weighted blend of that line and the two input lines before it. A freeze request stops memory updates so that the last complete field stays on display. Freeze, size and filter are taken into use only at a start-of-field strobe, so no field is ever half-written.

Two status flags are provided. A busy flag shows that the latest change to the controls has not yet produced a complete field in memory. A sync-loss flag shows that line strobes from the inset source have stopped arriving.

Top module: `pip_field_capture`

## Requirements
- R1: While reset is held, and in the cycle after it is released, `memWe` is 0, `writeBusy` is 0 and `noSync` is 1.
- R2: The horizontal decimation factor D is 4 when the applied size bit is 0 and 3 when it is 1. In a line, the samples kept are the valid samples whose index is a multiple of D. Samples are counted from 0, starting at the first valid sample after the line strobe. At most MAX_COLS samples are kept per line.
- R3: Lines are counted from 0, starting at the first line strobe after a field strobe. A line is stored when its index modulo D equals 2. At most MAX_ROWS lines are stored per field. Valid samples that arrive between a field strobe and the first line strobe are ignored.
- R4: With the applied filter bit at 1, each stored component equals (a + 2b + c + 2) >> 2. Here c is the sample of stored line n, b is the sample at the same kept position on line n-1, and a is the sample on line n-2. With the filter bit at 0, the component equals c.
- R5: A pixel kept at clock edge E is written in the three cycles that follow E. The words are, in order, {2'b00,Y}, {2'b01,U} and {2'b10,V}. The address starts at 0 after each field strobe and rises by one per write. Storage is row by row, left to right.
- R6: The freeze request is sampled at each field strobe. A field that starts while freeze is in effect writes nothing. A freeze request raised partway through a field does not interrupt that field. Writing resumes with the first field that starts after the request is cleared.
- R7: The size and filter inputs take effect only at a field strobe. A change in the middle of a field does not alter how the rest of that field is decimated.
- R8: `writeBusy` is 1 whenever the requested size, filter or freeze differs from the value in effect. A field strobe that applies a change without freeze keeps `writeBusy` at 1 until the next field strobe. In all other cases `writeBusy` is 0.
- R9: `noSync` is 0 from the cycle after a line strobe. It becomes 1 once H_TIMEOUT clock edges have passed with no line strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | A Y/U/V sample is present this cycle |
| ySample | input | 6 | Luma sample |
| uSample | input | 6 | First colour-difference sample |
| vSample | input | 6 | Second colour-difference sample |
| hStrobe | input | 1 | One-cycle start-of-line pulse from the inset source |
| vStrobe | input | 1 | One-cycle start-of-field pulse from the inset source |
| sizeNinth | input | 1 | Inset size request: 0 = one sixteenth, 1 = one ninth |
| filterOn | input | 1 | Vertical three-line filter request |
| freezeReq | input | 1 | Freeze request |
| memWe | output | 1 | Field memory write enable |
| memAddr | output | ADDR_W | Field memory word address |
| memData | output | 8 | Field memory write word |
| writeBusy | output | 1 | Latest control change not yet complete in memory |
| noSync | output | 1 | Line strobes from the inset source are missing |

## Verification
The main function is driven with whole fields. Each line is 16 samples long and each field has 14 lines. The sample values are quadratic in the line index, so the filtered and the plain results always differ. These fields are captured at both sizes, with and without the filter. This separates a wrong decimation phase, wrong column or row limits, wrong filter taps or rounding, and a wrong component order in the memory words. Each field also carries stray samples ahead of its first line strobe. The bench toggles size and freeze in the middle of fields, so a control applied too early shows up as a wrong factor or as a partly written field. Sequences of field strobes with and without pending changes pin down when the busy flag rises and falls.

// File: rtl/pip_cap_pkg.sv
package pip_cap_pkg;
  localparam int SAMPLE_W = 6;
  localparam int WORD_W   = 8;
  localparam int NCOMP    = 3;

  typedef logic [NCOMP-1:0][SAMPLE_W-1:0] pix_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_Y    = 2'd1,
    PH_U    = 2'd2,
    PH_V    = 2'd3
  } wr_phase_e;

  typedef struct packed {
    logic      shift;
    logic      capture;
    logic      useFilter;
    wr_phase_e phase;
  } cap_strobe_t;
endpackage

// File: rtl/pip_cap_ctrl.sv
module pip_cap_ctrl
  import pip_cap_pkg::*;
#(
  parameter int MAX_COLS  = 64,
  parameter int MAX_ROWS  = 40,
  parameter int ADDR_W    = 13,
  parameter int H_TIMEOUT = 1024,
  localparam int COL_W    = $clog2(MAX_COLS + 1),
  localparam int IDX_W    = $clog2(MAX_COLS),
  localparam int ROW_W    = $clog2(MAX_ROWS + 1),
  localparam int GAP_W    = $clog2(H_TIMEOUT + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic              hStrobe,
  input  logic              vStrobe,
  input  logic              sizeNinth,
  input  logic              filterOn,
  input  logic              freezeReq,
  output cap_strobe_t       strobes,
  output logic [IDX_W-1:0]  colIdx,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic              writeBusy,
  output logic              noSync,
  output logic              frozen
);
  logic appSize, appFilt, appFreeze, settle;
  logic [2:0] decim, sGrp, lineGrp;
  logic lineActive;
  logic [COL_W-1:0] colCnt;
  logic [ROW_W-1:0] rowCnt;
  logic [GAP_W-1:0] hGap;
  wr_phase_e phase;
  logic reqDiff, keepCol, rowKept, capture, inLine;

  assign decim   = appSize ? 3'd3 : 3'd4;
  assign reqDiff = {sizeNinth, filterOn, freezeReq} != {appSize, appFilt, appFreeze};
  assign inLine  = sampleValid && lineActive && !hStrobe && !vStrobe;
  assign keepCol = inLine && (sGrp == 3'd0) && (colCnt < COL_W'(MAX_COLS));
  assign rowKept = (lineGrp == 3'd2) && (rowCnt < ROW_W'(MAX_ROWS));
  assign capture = keepCol && rowKept && !appFreeze;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      appSize    <= 1'b0;
      appFilt    <= 1'b0;
      appFreeze  <= 1'b0;
      settle     <= 1'b0;
      lineActive <= 1'b0;
      lineGrp    <= 3'd0;
      sGrp       <= 3'd0;
      colCnt     <= '0;
      rowCnt     <= '0;
    end else if (vStrobe) begin
      appSize    <= sizeNinth;
      appFilt    <= filterOn;
      appFreeze  <= freezeReq;
      settle     <= reqDiff && !freezeReq;
      lineActive <= 1'b0;
      lineGrp    <= 3'd0;
      sGrp       <= 3'd0;
      colCnt     <= '0;
      rowCnt     <= '0;
    end else if (hStrobe) begin
      if (lineActive && rowKept) rowCnt <= rowCnt + 1'b1;
      if (!lineActive || lineGrp == decim - 3'd1) lineGrp <= 3'd0;
      else lineGrp <= lineGrp + 3'd1;
      lineActive <= 1'b1;
      sGrp       <= 3'd0;
      colCnt     <= '0;
    end else if (inLine) begin
      sGrp <= (sGrp == decim - 3'd1) ? 3'd0 : sGrp + 3'd1;
      if (keepCol) colCnt <= colCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      memAddr <= '0;
    end else begin
      if (capture) phase <= PH_Y;
      else begin
        unique case (phase)
          PH_Y:    phase <= PH_U;
          PH_U:    phase <= PH_V;
          default: phase <= PH_IDLE;
        endcase
      end
      if (vStrobe) memAddr <= '0;
      else if (phase != PH_IDLE) memAddr <= memAddr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) hGap <= GAP_W'(H_TIMEOUT);
    else if (hStrobe) hGap <= '0;
    else if (hGap < GAP_W'(H_TIMEOUT)) hGap <= hGap + 1'b1;
  end

  assign strobes.shift     = keepCol;
  assign strobes.capture   = capture;
  assign strobes.useFilter = appFilt;
  assign strobes.phase     = phase;
  assign colIdx    = colCnt[IDX_W-1:0];
  assign memWe     = phase != PH_IDLE;
  assign writeBusy = reqDiff || settle;
  assign noSync    = hGap >= GAP_W'(H_TIMEOUT);
  assign frozen    = appFreeze;
endmodule

// File: rtl/pip_cap_datapath.sv
module pip_cap_datapath
  import pip_cap_pkg::*;
#(
  parameter int MAX_COLS = 64,
  localparam int IDX_W   = $clog2(MAX_COLS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  cap_strobe_t       strobes,
  input  logic [IDX_W-1:0]  colIdx,
  input  logic [SAMPLE_W-1:0] ySample,
  input  logic [SAMPLE_W-1:0] uSample,
  input  logic [SAMPLE_W-1:0] vSample,
  output logic [WORD_W-1:0] memData
);
  pix_t lineA [MAX_COLS];
  pix_t lineB [MAX_COLS];
  pix_t cur, prev1, prev2, blended, hold;

  assign cur   = {vSample, uSample, ySample};
  assign prev1 = lineA[colIdx];
  assign prev2 = lineB[colIdx];

  for (genvar k = 0; k < NCOMP; k++) begin : g_blend
    logic [SAMPLE_W+1:0] sum;
    assign sum = {2'b00, prev2[k]} + {1'b0, prev1[k], 1'b0} + {2'b00, cur[k]}
               + (SAMPLE_W+2)'(2);
    assign blended[k] = sum[SAMPLE_W+1:2];
  end

  always_ff @(posedge clk) begin
    if (strobes.shift) begin
      lineB[colIdx] <= prev1;
      lineA[colIdx] <= cur;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) hold <= '0;
    else if (strobes.capture) hold <= strobes.useFilter ? blended : cur;
  end

  always_comb begin
    unique case (strobes.phase)
      PH_Y:    memData = {2'b00, hold[0]};
      PH_U:    memData = {2'b01, hold[1]};
      PH_V:    memData = {2'b10, hold[2]};
      default: memData = '0;
    endcase
  end
endmodule

// File: rtl/pip_field_capture.sv
module pip_field_capture
  import pip_cap_pkg::*;
#(
  parameter int MAX_COLS  = 64,
  parameter int MAX_ROWS  = 40,
  parameter int ADDR_W    = 13,
  parameter int H_TIMEOUT = 1024,
  localparam int IDX_W    = $clog2(MAX_COLS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic [5:0]        ySample,
  input  logic [5:0]        uSample,
  input  logic [5:0]        vSample,
  input  logic              hStrobe,
  input  logic              vStrobe,
  input  logic              sizeNinth,
  input  logic              filterOn,
  input  logic              freezeReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memData,
  output logic              writeBusy,
  output logic              noSync
);
  cap_strobe_t strobes;
  logic [IDX_W-1:0] colIdx;
  logic frozen;

  pip_cap_ctrl #(
    .MAX_COLS(MAX_COLS), .MAX_ROWS(MAX_ROWS),
    .ADDR_W(ADDR_W), .H_TIMEOUT(H_TIMEOUT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .hStrobe(hStrobe), .vStrobe(vStrobe),
    .sizeNinth(sizeNinth), .filterOn(filterOn), .freezeReq(freezeReq),
    .strobes(strobes), .colIdx(colIdx), .memWe(memWe), .memAddr(memAddr),
    .writeBusy(writeBusy), .noSync(noSync), .frozen(frozen)
  );

  pip_cap_datapath #(.MAX_COLS(MAX_COLS)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .colIdx(colIdx),
    .ySample(ySample), .uSample(uSample), .vSample(vSample),
    .memData(memData)
  );
endmodule

// File: rtl/pip_field_capture_chk.sv
module pip_field_capture_chk #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rstN,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [7:0]        memData,
  input logic              hStrobe,
  input logic              vStrobe,
  input logic              noSync,
  input logic              frozen
);
  assert_tag_legal_R5: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> memData[7:6] != 2'b11);

  assert_y_then_u_R5: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && memData[7:6] == 2'b00) |=> (memWe && memData[7:6] == 2'b01));

  assert_u_then_v_R5: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && memData[7:6] == 2'b01) |=> (memWe && memData[7:6] == 2'b10));

  assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && !vStrobe) |=> memAddr == ADDR_W'($past(memAddr) + 1'b1));

  assert_addr_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    vStrobe |=> memAddr == '0);

  assert_frozen_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    (frozen && $past(frozen, 3)) |-> !memWe);

  assert_sync_seen_R9: assert property (@(posedge clk) disable iff (!rstN)
    hStrobe |=> !noSync);
endmodule

bind pip_field_capture pip_field_capture_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .memWe(memWe), .memAddr(memAddr), .memData(memData),
  .hStrobe(hStrobe), .vStrobe(vStrobe), .noSync(noSync), .frozen(frozen)
);

// File: tb/tb_pip_field_capture.sv
module tb_pip_field_capture;
  localparam int MAX_COLS  = 4;
  localparam int MAX_ROWS  = 3;
  localparam int ADDR_W    = 13;
  localparam int H_TIMEOUT = 64;
  localparam int LINE_LEN  = 16;
  localparam int LINES     = 14;
  localparam int WORDS     = 3 * MAX_COLS * MAX_ROWS;
  localparam int RAM_D     = 64;
  // {size, filter, seed[5:0]}
  localparam logic [7:0] CASES [4] = '{8'h05, 8'h86, 8'h47, 8'hC8};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleValid = 1'b0, hStrobe = 1'b0, vStrobe = 1'b0;
  logic sizeNinth = 1'b0, filterOn = 1'b0, freezeReq = 1'b0;
  logic [5:0] ySample = '0, uSample = '0, vSample = '0;
  logic memWe, writeBusy, noSync;
  logic [ADDR_W-1:0] memAddr;
  logic [7:0] memData;
  logic clearRam = 1'b0;
  logic [7:0] ram [RAM_D];
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pip_field_capture #(.MAX_COLS(MAX_COLS), .MAX_ROWS(MAX_ROWS),
    .ADDR_W(ADDR_W), .H_TIMEOUT(H_TIMEOUT)) dut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .ySample(ySample), .uSample(uSample), .vSample(vSample),
    .hStrobe(hStrobe), .vStrobe(vStrobe), .sizeNinth(sizeNinth),
    .filterOn(filterOn), .freezeReq(freezeReq), .memWe(memWe),
    .memAddr(memAddr), .memData(memData), .writeBusy(writeBusy), .noSync(noSync));

  always @(posedge clk) begin
    if (clearRam) begin
      for (int i = 0; i < RAM_D; i++) ram[i] <= 8'hFF;
    end else if (memWe && memAddr < ADDR_W'(RAM_D)) begin
      ram[memAddr[5:0]] <= memData;
    end
  end

  function automatic logic [5:0] pixVal(int comp, int line, int s, int seed);
    return 6'((comp * 21 + line * line * 3 + s * 5 + seed * 11 + line * s) & 63);
  endfunction

  function automatic logic [7:0] expWord(int k, int d, bit filt, int seed);
    int r, c, comp, n, s, v;
    r = k / (3 * MAX_COLS);
    c = (k / 3) % MAX_COLS;
    comp = k % 3;
    n = r * d + 2;
    s = c * d;
    if (filt)
      v = (int'(pixVal(comp, n - 2, s, seed)) + 2 * int'(pixVal(comp, n - 1, s, seed))
           + int'(pixVal(comp, n, s, seed)) + 2) >> 2;
    else
      v = int'(pixVal(comp, n, s, seed));
    return {2'(comp), 6'(v)};
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulseV();
    vStrobe = 1'b1; @(negedge clk); vStrobe = 1'b0; @(negedge clk);
  endtask

  task automatic runField(int seed, int freezeAt, int sizeAt, bit expectWrites);
    clearRam = 1'b1; @(negedge clk); clearRam = 1'b0;
    pulseV();
    // stray samples before the first line strobe must be ignored (R3)
    for (int i = 0; i < 2; i++) begin
      ySample = 6'h3F; uSample = 6'h3F; vSample = 6'h3F; sampleValid = 1'b1;
      @(negedge clk);
    end
    sampleValid = 1'b0;
    for (int line = 0; line < LINES; line++) begin
      if (line == freezeAt) freezeReq = 1'b1;
      if (line == sizeAt) sizeNinth = ~sizeNinth;
      hStrobe = 1'b1; @(negedge clk); hStrobe = 1'b0;
      for (int s = 0; s < LINE_LEN; s++) begin
        if (expectWrites && line == 2 && s == 1)
          check(memWe && memAddr == '0 && memData[7:6] == 2'b00, "R5 first write timing",
                {memWe, memData}, {1'b1, 8'h00});
        ySample = pixVal(0, line, s, seed);
        uSample = pixVal(1, line, s, seed);
        vSample = pixVal(2, line, s, seed);
        sampleValid = 1'b1;
        @(negedge clk);
      end
      sampleValid = 1'b0;
      repeat (4) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic checkField(string req, int d, bit filt, int seed);
    for (int k = 0; k < WORDS; k++)
      check(ram[k] == expWord(k, d, filt, seed), req, ram[k], expWord(k, d, filt, seed));
    check(ram[WORDS] == 8'hFF, {req, " R5 word count"}, ram[WORDS], 8'hFF);
  endtask

  task automatic checkBlank(string req);
    int bad = 0;
    for (int k = 0; k <= WORDS; k++) if (ram[k] != 8'hFF) bad++;
    check(bad == 0, req, bad, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!memWe && !writeBusy && noSync, "R1 in reset", {memWe, writeBusy, noSync}, 3'b001);
    rstN = 1'b1;
    @(negedge clk);
    check(!memWe && !writeBusy && noSync, "R1 after reset", {memWe, writeBusy, noSync}, 3'b001);

    // table of configurations: R2 size, R3 rows, R4 filter
    for (int i = 0; i < 4; i++) begin
      sizeNinth = CASES[i][7];
      filterOn  = CASES[i][6];
      runField(int'(CASES[i][5:0]), -1, -1, 1'b1);
      checkField(CASES[i][6] ? "R4 filtered field" : "R2 R3 plain field",
                 CASES[i][7] ? 3 : 4, CASES[i][6], int'(CASES[i][5:0]));
      check(!noSync, "R9 strobes present", noSync, 0);
    end

    // R7: size change inside a field waits for the next field strobe
    sizeNinth = 1'b0; filterOn = 1'b0;
    runField(9, -1, 4, 1'b1);
    checkField("R7 mid-field size change", 4, 1'b0, 9);
    check(writeBusy, "R8 pending change", writeBusy, 1);

    // R6: freeze raised mid-field does not cut the field
    runField(13, 5, -1, 1'b1);
    checkField("R6 mid-field freeze", 3, 1'b0, 13);
    check(writeBusy, "R8 freeze pending", writeBusy, 1);

    // R6: frozen field writes nothing
    runField(17, -1, -1, 1'b0);
    checkBlank("R6 frozen field");
    check(!writeBusy, "R8 freeze applied", writeBusy, 0);

    // R6: release resumes writing
    @(negedge clk); freezeReq = 1'b0; @(negedge clk);
    check(writeBusy, "R8 release pending", writeBusy, 1);
    runField(21, -1, -1, 1'b1);
    checkField("R6 resumed field", 3, 1'b0, 21);
    check(writeBusy, "R8 first field after change", writeBusy, 1);
    pulseV();
    check(!writeBusy, "R8 settled", writeBusy, 0);

    // R9: sync timeout boundary
    hStrobe = 1'b1; @(negedge clk); hStrobe = 1'b0;
    repeat (63) @(negedge clk);
    check(!noSync, "R9 just before timeout", noSync, 0);
    @(negedge clk);
    check(noSync, "R9 timeout", noSync, 1);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule